// File: doc/BRIEF.md
# Two-Wire Parity Serial Engine

This block is the bus-side engine of a host controller for a two-wire clock/data serial bus. The host presents one command at a time: a command code, an 8-bit runtime slave address, an 8-bit register address, a 16-bit device hardware address for address assignment, and up to four write data bytes. The engine then generates SCL from an internal divider and shifts every field out on SDA, most significant bit first. Each byte is followed by an even parity bit. No slave acknowledge is expected after a byte.

A register read is a single frame. The engine sends the command, the runtime address and the register address. It releases SDA for one turnaround slot and then samples the returned bytes together with their parity bits. A write or an address assignment leaves one slot in which the slave must pull SDA low. When the frame ends, the engine gives a one-cycle done pulse. At that pulse the received data, an acknowledge-error flag and a data-error flag with the index of the failing byte are valid.

Top module: `twp_engine`

## Requirements
- R1: After reset and whenever no frame is running, scl_o is 1, sda_o is 1, sda_oe is 0, and busy and done are 0.
- R2: SCL has a period of 2*(div+1) clk cycles. A frame starts with the low half of its first slot. The slave samples each bit slot on the rising SCL edge.
- R3: Every driven byte goes out bit 7 first. It is followed by one even parity bit, equal to the XOR of its 8 bits. SDA and its enable never change while SCL stays high.
- R4: Every SDA change happens min(sda_dly, div) clk cycles after the falling SCL edge that opens the slot.
- R5: The command codes are 0x8B, 0x9C and 0xA6 (read 1, 2 or 4 bytes), 0x4E, 0x59 and 0x63 (write 1, 2 or 4 bytes), and 0xE8 (assign runtime address). A start with any other code is ignored: busy stays 0 and SCL does not toggle.
- R6: A read frame contains, in this order: the command, rt_addr and reg_addr, each driven with parity; one released turnaround slot; then N released slots of 8 data bits plus parity each. Byte k of the returned data lands in rdata[8k+7:8k], and bytes that were not read are 0.
- R7: A write frame contains, in this order: the command, rt_addr and reg_addr, each with parity; one released acknowledge slot; then N data bytes with parity, taken from wdata[7:0] first.
- R8: An address-assignment frame contains, in this order: 0xE8, dev_addr[15:8], dev_addr[7:0] and rt_addr, each with parity; then one released acknowledge slot.
- R9: If SDA is high in an acknowledge slot, ack_err is set and the frame ends after that slot, before any data byte is sent.
- R10: If a received parity bit does not match its byte, data_err is set and err_byte holds the byte index (0 for the first byte). The frame ends after that slot. Bytes received earlier stay in rdata.
- R11: After the last bit slot there is one released trailing slot. done is a one-cycle pulse, asserted with the rising SCL edge that closes the trailing slot, with busy low. rdata, ack_err, data_err and err_byte clear when a start is accepted and hold until the next accepted start.
- R12: A start that arrives while a frame is running is ignored, and the running frame continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse; samples all command inputs |
| cmd | input | 8 | Command code |
| rt_addr | input | 8 | Runtime slave address |
| reg_addr | input | 8 | Register address |
| dev_addr | input | 16 | Hardware device address for address assignment |
| wdata | input | 32 | Write data, least significant byte sent first |
| div | input | DIV_W | SCL divider |
| sda_dly | input | DLY_W | SDA output delay in clk cycles |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_o | output | 1 | Serial clock |
| sda_o | output | 1 | SDA value driven when enabled |
| sda_oe | output | 1 | SDA drive enable |
| busy | output | 1 | A frame is running |
| done | output | 1 | End-of-frame pulse |
| ack_err | output | 1 | Acknowledge slot sampled high |
| data_err | output | 1 | Received parity mismatch |
| err_byte | output | EW | Index of the byte whose parity failed |
| rdata | output | 32 | Received data |

## Verification
Reads of one, two and four bytes show that the byte count comes from the command and that bytes are assembled least significant first. A four-byte read with the parity of the second byte flipped shows that the frame stops early and that the earlier byte is kept. Writes with a low and then a high acknowledge level show the difference between a frame that carries data and one cut off after the address. The address-assignment frame is driven with both acknowledge levels as well. Two divider and delay settings, one of them with a delay larger than the divider, pin down the SCL period and the clamped SDA delay. An unknown code and a start issued in the middle of a frame confirm that both are ignored.

// File: rtl/twp_pkg.sv
package twp_pkg;

   localparam int DATA_BYTES = 4;

   typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR, OP_SETADR} op_e;

   typedef enum logic [2:0] {S_IDLE, S_SEND, S_ACK, S_TURN, S_RECV, S_TAIL} st_e;

   typedef struct packed {
      op_e        op;
      logic [2:0] nbytes;
   } cmd_info_t;

   function automatic cmd_info_t decode_cmd(input logic [7:0] c);
      cmd_info_t r;
      r.op     = OP_NONE;
      r.nbytes = 3'd0;
      case (c)
         8'h8B: r = '{OP_RD, 3'd1};
         8'h9C: r = '{OP_RD, 3'd2};
         8'hA6: r = '{OP_RD, 3'd4};
         8'h4E: r = '{OP_WR, 3'd1};
         8'h59: r = '{OP_WR, 3'd2};
         8'h63: r = '{OP_WR, 3'd4};
         8'hE8: r = '{OP_SETADR, 3'd0};
         default: ;
      endcase
      return r;
   endfunction

   function automatic logic par_even(input logic [7:0] b);
      return ^b;
   endfunction

endpackage

// File: rtl/twp_sclgen.sv
module twp_sclgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             kick,
   input  logic [DIV_W-1:0] div,
   output logic             scl,
   output logic             rise_ev,
   output logic             fall_ev
);

   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap    = (cnt == div);
   assign rise_ev = run && !scl && wrap;
   assign fall_ev = run && scl && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         scl <= 1'b1;
      end else if (kick) begin
         cnt <= '0;
         scl <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         scl <= 1'b1;
      end else if (wrap) begin
         cnt <= '0;
         scl <= ~scl;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // a frame always opens with the low half of a slot
   assert_low_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !scl);

endmodule

// File: rtl/twp_sda_delay.sv
module twp_sda_delay #(
   parameter int DLY_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             bit_in,
   input  logic             oe_in,
   input  logic [DLY_W-1:0] dly,
   output logic             sda,
   output logic             sda_oe
);

   logic [DLY_W-1:0] cnt;
   logic             armed;
   logic             pend_bit;
   logic             pend_oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda      <= 1'b1;
         sda_oe   <= 1'b0;
         cnt      <= '0;
         armed    <= 1'b0;
         pend_bit <= 1'b1;
         pend_oe  <= 1'b0;
      end else if (load) begin
         if (dly == '0) begin
            sda    <= bit_in;
            sda_oe <= oe_in;
            armed  <= 1'b0;
         end else begin
            pend_bit <= bit_in;
            pend_oe  <= oe_in;
            cnt      <= dly - 1'b1;
            armed    <= 1'b1;
         end
      end else if (armed) begin
         if (cnt == '0) begin
            sda    <= pend_bit;
            sda_oe <= pend_oe;
            armed  <= 1'b0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // a pending change must land before the next slot loads
   assert_delay_fits_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !armed);

endmodule

// File: rtl/twp_engine.sv
module twp_engine
   import twp_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int DLY_W = 3,
   parameter int EW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       cmd,
   input  logic [7:0]       rt_addr,
   input  logic [7:0]       reg_addr,
   input  logic [15:0]      dev_addr,
   input  logic [31:0]      wdata,
   input  logic [DIV_W-1:0] div,
   input  logic [DLY_W-1:0] sda_dly,
   input  logic             sda_i,
   output logic             scl_o,
   output logic             sda_o,
   output logic             sda_oe,
   output logic             busy,
   output logic             done,
   output logic             ack_err,
   output logic             data_err,
   output logic [EW-1:0]    err_byte,
   output logic [31:0]      rdata
);

   localparam int CNT_W = $clog2(DATA_BYTES) + 1;

   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("DLY_W must be at least 1");
   end
   if (EW < CNT_W - 1) begin : g_bad_ew
      $error("EW too narrow for the byte index");
   end

   st_e              st, n_st;
   op_e              op;
   logic [2:0]       nb;
   logic             dphase, n_dph, abort;
   logic [31:0]      q, n_q, wd_q, wd_sw;
   logic [2:0]       qn, n_qn;
   logic [CNT_W-1:0] bidx, n_bidx;
   logic [3:0]       bitn, n_bit;
   logic [7:0]       rxb, n_cur;
   logic [DIV_W-1:0] div_q;
   logic [DLY_W-1:0] dly_q, dly_now;
   logic             n_drv, n_val;
   logic             rise_ev, fall_ev, accept, run, rx_ok;
   cmd_info_t        ci;

   assign ci     = decode_cmd(cmd);
   assign accept = start && (st == S_IDLE) && (ci.op != OP_NONE);
   assign run    = (st != S_IDLE);
   assign busy   = run;
   assign wd_sw  = {wd_q[7:0], wd_q[15:8], wd_q[23:16], wd_q[31:24]};
   assign rx_ok  = (sda_i == par_even(rxb));

   always_comb begin
      if (int'(sda_dly) > int'(div)) dly_now = DLY_W'(div);
      else                           dly_now = sda_dly;
   end

   // next slot, taken at each falling SCL edge
   always_comb begin
      n_st   = st;
      n_q    = q;
      n_qn   = qn;
      n_bidx = bidx;
      n_bit  = bitn;
      n_dph  = dphase;
      case (st)
         S_SEND: begin
            if (bitn != 4'd8) begin
               n_bit = bitn + 4'd1;
            end else if (3'(bidx + 1'b1) < qn) begin
               n_bidx = bidx + 1'b1;
               n_bit  = 4'd0;
               n_q    = {q[23:0], 8'h00};
            end else begin
               n_bit  = 4'd0;
               n_bidx = '0;
               if (op == OP_RD)                n_st = S_TURN;
               else if (op == OP_WR && dphase) n_st = S_TAIL;
               else                            n_st = S_ACK;
            end
         end
         S_ACK: begin
            if (abort || op != OP_WR) begin
               n_st = S_TAIL;
            end else begin
               n_st   = S_SEND;
               n_dph  = 1'b1;
               n_q    = wd_sw;
               n_qn   = nb;
               n_bidx = '0;
               n_bit  = 4'd0;
            end
         end
         S_TURN: begin
            n_st   = S_RECV;
            n_bidx = '0;
            n_bit  = 4'd0;
         end
         S_RECV: begin
            if (abort)                         n_st = S_TAIL;
            else if (bitn != 4'd8)             n_bit = bitn + 4'd1;
            else if (3'(bidx + 1'b1) < nb) begin
               n_bidx = bidx + 1'b1;
               n_bit  = 4'd0;
            end else                           n_st = S_TAIL;
         end
         default: ;
      endcase
      n_cur = n_q[31:24];
      n_drv = (n_st == S_SEND);
      if (!n_drv)              n_val = 1'b1;
      else if (n_bit == 4'd8)  n_val = par_even(n_cur);
      else                     n_val = n_cur[3'd7 - n_bit[2:0]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         op       <= OP_NONE;
         nb       <= 3'd0;
         dphase   <= 1'b0;
         abort    <= 1'b0;
         q        <= '0;
         qn       <= 3'd0;
         wd_q     <= '0;
         bidx     <= '0;
         bitn     <= 4'd0;
         rxb      <= 8'h00;
         div_q    <= '0;
         dly_q    <= '0;
         done     <= 1'b0;
         ack_err  <= 1'b0;
         data_err <= 1'b0;
         err_byte <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            st       <= S_SEND;
            op       <= ci.op;
            nb       <= ci.nbytes;
            dphase   <= 1'b0;
            abort    <= 1'b0;
            bidx     <= '0;
            bitn     <= 4'd0;
            rxb      <= 8'h00;
            wd_q     <= wdata;
            div_q    <= div;
            dly_q    <= dly_now;
            ack_err  <= 1'b0;
            data_err <= 1'b0;
            err_byte <= '0;
            if (ci.op == OP_SETADR) begin
               q  <= {cmd, dev_addr, rt_addr};
               qn <= 3'd4;
            end else begin
               q  <= {cmd, rt_addr, reg_addr, 8'h00};
               qn <= 3'd3;
            end
         end else if (fall_ev) begin
            st     <= n_st;
            q      <= n_q;
            qn     <= n_qn;
            bidx   <= n_bidx;
            bitn   <= n_bit;
            dphase <= n_dph;
         end else if (rise_ev) begin
            case (st)
               S_ACK: if (sda_i) begin
                  ack_err <= 1'b1;
                  abort   <= 1'b1;
               end
               S_RECV: begin
                  if (bitn != 4'd8) begin
                     rxb <= {rxb[6:0], sda_i};
                  end else if (!rx_ok) begin
                     data_err <= 1'b1;
                     err_byte <= EW'(bidx);
                     abort    <= 1'b1;
                  end
               end
               S_TAIL: begin
                  st   <= S_IDLE;
                  done <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lane_q <= 8'h00;
         else if (accept)
            lane_q <= 8'h00;
         else if (rise_ev && st == S_RECV && bitn == 4'd8 && rx_ok && bidx == CNT_W'(g))
            lane_q <= rxb;
      end
      assign rdata[8*g +: 8] = lane_q;
   end

   twp_sclgen #(.DIV_W(DIV_W)) u_scl (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .kick    (accept),
      .div     (div_q),
      .scl     (scl_o),
      .rise_ev (rise_ev),
      .fall_ev (fall_ev)
   );

   twp_sda_delay #(.DLY_W(DLY_W)) u_sda (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept || fall_ev),
      .bit_in (accept ? cmd[7] : n_val),
      .oe_in  (accept ? 1'b1 : n_drv),
      .dly    (accept ? dly_now : dly_q),
      .sda    (sda_o),
      .sda_oe (sda_oe)
   );

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sda_oe);

   assert_sda_quiet_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_o && $past(scl_o)) |-> ($stable(sda_o) && $stable(sda_oe)));

   assert_busy_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_err && data_err));

   assert_done_at_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (scl_o && !busy));

   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/sim_twp_engine.sv
module sim_twp_engine;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  cmd = 8'h00, rt_addr = 8'h00, reg_addr = 8'h00;
   logic [15:0] dev_addr = 16'h0000;
   logic [31:0] wdata = 32'h0;
   logic [7:0]  div = 8'd1;
   logic [2:0]  sda_dly = 3'd1;
   logic        sda_i = 1'b1;
   logic        scl_o, sda_o, sda_oe, busy, done, ack_err, data_err;
   logic [3:0]  err_byte;
   logic [31:0] rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   twp_engine u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .rt_addr(rt_addr),
      .reg_addr(reg_addr), .dev_addr(dev_addr), .wdata(wdata), .div(div),
      .sda_dly(sda_dly), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
      .sda_oe(sda_oe), .busy(busy), .done(done), .ack_err(ack_err),
      .data_err(data_err), .err_byte(err_byte), .rdata(rdata)
   );

   int  n_checks = 0;
   int  n_errs = 0;
   logic mb [128];
   logic mo [128];
   int  rc = 0;
   time t_prev = 0, t_last = 0, t_fall = 0;
   time dmin = 0, dmax = 0;
   logic eb [128];
   logic eo [128];
   logic rs [128];
   int  en = 0;

   // bus monitor: one record per rising SCL edge
   initial forever begin
      @(posedge scl_o);
      if (rc < 128) begin
         mb[rc] = sda_o;
         mo[rc] = sda_oe;
      end
      t_prev = t_last;
      t_last = $time;
      rc++;
   end

   // slave responder: level for slot rc, set after each falling edge
   initial forever begin
      @(negedge scl_o);
      t_fall = $time;
      sda_i = (rc < en) ? rs[rc] : 1'b1;
   end

   // SDA change delay watcher
   initial forever begin
      @(sda_o);
      if ($time - t_fall < dmin) dmin = $time - t_fall;
      if ($time - t_fall > dmax) dmax = $time - t_fall;
   end

   task automatic check(input logic ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic b, input logic oe, input logic r);
      eb[en] = b; eo[en] = oe; rs[en] = r; en++;
   endtask

   task automatic drive_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) push(b[i], 1'b1, 1'b1);
      push(^b, 1'b1, 1'b1);
   endtask

   task automatic rx_byte(input logic [7:0] b, input logic bad);
      for (int i = 7; i >= 0; i--) push(1'b0, 1'b0, b[i]);
      push(1'b0, 1'b0, (^b) ^ bad);
   endtask

   task automatic launch(input logic [7:0] c);
      @(negedge clk);
      cmd = c;
      rc = 0;
      dmin = 64'hFFFF_FFFF;
      dmax = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int i;
      for (i = 0; i < 6000; i++) begin
         @(negedge clk);
         if (done) break;
      end
      if (i == 6000) begin
         check(1'b0, req, "done never seen", 0, 1);
      end else begin
         check(scl_o && !busy, "R11", "scl/busy at done", {scl_o, busy}, 2'b10);
         @(negedge clk);
         check(!done, "R11", "done width", done, 0);
      end
   endtask

   task automatic check_frame(input string req);
      int bad = -1;
      check(rc == en + 1, req, "slot count", rc, en + 1);
      for (int k = 0; k < en && k < 128; k++)
         if (bad < 0 && (mo[k] !== eo[k] || (eo[k] && mb[k] !== eb[k]))) bad = k;
      if (bad < 0 && en < 128 && mo[en] !== 1'b0) bad = en;
      if (bad >= 0)
         check(1'b0, req, $sformatf("slot %0d {oe,bit}", bad),
               {mo[bad], mb[bad]}, {eo[bad], (bad < en) ? eb[bad] : 1'b0});
      else
         check(1'b1, req, "frame", 0, 0);
   endtask

   task automatic t_read(input logic [7:0] c, input int n, input logic [31:0] d,
                         input int badi, input string req);
      logic [31:0] exp_rd = 32'h0;
      en = 0;
      rt_addr = 8'h2D; reg_addr = 8'h5A;
      drive_byte(c); drive_byte(8'h2D); drive_byte(8'h5A);
      push(1'b0, 1'b0, 1'b1);
      for (int i = 0; i < n; i++) begin
         rx_byte(d[8*i +: 8], i == badi);
         if (i == badi) break;
         exp_rd[8*i +: 8] = d[8*i +: 8];
      end
      launch(c);
      wait_done(req);
      check_frame(req);
      check(rdata == exp_rd, req, "rdata", rdata, exp_rd);
      check(data_err == (badi >= 0), "R10", "data_err", data_err, badi >= 0);
      if (badi >= 0) check(err_byte == 4'(badi), "R10", "err_byte", err_byte, badi);
   endtask

   task automatic t_write(input logic [7:0] c, input int n, input logic [31:0] d,
                          input logic nack, input string req);
      en = 0;
      rt_addr = 8'h3A; reg_addr = 8'hC3; wdata = d;
      drive_byte(c); drive_byte(8'h3A); drive_byte(8'hC3);
      push(1'b0, 1'b0, nack);
      if (!nack) for (int i = 0; i < n; i++) drive_byte(d[8*i +: 8]);
      launch(c);
      wait_done(req);
      check_frame(req);
      check(ack_err == nack, "R9", "ack_err", ack_err, nack);
   endtask

   task automatic t_setadr(input logic [15:0] hw, input logic [7:0] rta, input logic nack);
      en = 0;
      dev_addr = hw; rt_addr = rta;
      drive_byte(8'hE8); drive_byte(hw[15:8]); drive_byte(hw[7:0]); drive_byte(rta);
      push(1'b0, 1'b0, nack);
      launch(8'hE8);
      wait_done("R8");
      check_frame("R8");
      check(ack_err == nack, "R9", "ack_err on assign", ack_err, nack);
   endtask

   task automatic t_reset;
      check(scl_o === 1'b1 && sda_oe === 1'b0 && sda_o === 1'b1 && busy === 1'b0 && done === 1'b0,
            "R1", "idle outputs {scl,oe,sda,busy,done}",
            {scl_o, sda_oe, sda_o, busy, done}, 5'b10100);
   endtask

   task automatic t_badcmd;
      en = 0;
      launch(8'h55);
      repeat (20) @(negedge clk);
      check(!busy && scl_o && rc == 0, "R5", "unknown code ignored {busy,scl,rises}",
            {busy, scl_o, 8'(rc)}, {1'b0, 1'b1, 8'd0});
   endtask

   task automatic t_busy_start;
      en = 0;
      rt_addr = 8'h2D; reg_addr = 8'h5A;
      drive_byte(8'hA6); drive_byte(8'h2D); drive_byte(8'h5A);
      push(1'b0, 1'b0, 1'b1);
      rx_byte(8'h11, 1'b0); rx_byte(8'h22, 1'b0); rx_byte(8'h33, 1'b0); rx_byte(8'h44, 1'b0);
      launch(8'hA6);
      repeat (30) @(negedge clk);
      cmd = 8'h4E; rt_addr = 8'h00; reg_addr = 8'h00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R12");
      check_frame("R12");
      check(rdata == 32'h44332211, "R12", "rdata after ignored start", rdata, 32'h44332211);
   endtask

   task automatic t_timing(input logic [7:0] d, input logic [2:0] dl, input int eff);
      div = d; sda_dly = dl;
      t_read(8'h8B, 1, 32'h0000_00A5, -1, "R6");
      check(t_last - t_prev == time'(2 * (d + 1) * CLK_PERIOD), "R2", "SCL period",
            32'(t_last - t_prev), 2 * (d + 1) * CLK_PERIOD);
      check(dmin == time'(eff * CLK_PERIOD) && dmax == time'(eff * CLK_PERIOD), "R4",
            "SDA delay min/max", {16'(dmin), 16'(dmax)},
            {16'(eff * CLK_PERIOD), 16'(eff * CLK_PERIOD)});
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read(8'h8B, 1, 32'h0000_003C, -1, "R6");
      t_read(8'h9C, 2, 32'h0000_BEEF, -1, "R6");
      t_read(8'hA6, 4, 32'hDEAD_0F71, -1, "R6");
      t_read(8'hA6, 4, 32'h1234_5678, 1, "R10");
      t_read(8'h8B, 1, 32'h0000_0081, -1, "R11");
      t_write(8'h4E, 1, 32'h0000_0096, 1'b0, "R7");
      t_write(8'h63, 4, 32'hCAFE_1357, 1'b0, "R7");
      t_write(8'h59, 2, 32'h0000_ABCD, 1'b1, "R9");
      t_setadr(16'h03A3, 8'h2D, 1'b0);
      t_setadr(16'h0745, 8'h3A, 1'b1);
      t_badcmd();
      t_busy_start();
      t_reset();
      t_timing(8'd4, 3'd2, 2);
      t_timing(8'd1, 3'd6, 1);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule